// File: doc/BRIEF.md
# Error-Severity Freeze Controller

This controller paces event processing and decides how the system reacts to a reported fault. Two processing paths, the hit path and the road path, each mark the end of an event with a one-cycle marker. Once both markers for the current event have arrived, the controller raises a one-cycle event-init pulse and starts collecting markers for the next event. The first event-init follows reset on its own.

Faults arrive on a valid/ready stream. Each fault carries a kind code and a mask of the streams involved. The controller compares the kind with a threshold held on a plain input pin. A fault below the threshold removes the named streams without stopping the system, through a sticky disable mask. A fault at or above the threshold requests a global freeze. The freeze waits until the event in flight has been fully processed, meaning both of its end markers have arrived. It is then driven to the downstream devices and to the upstream source at the same time, and it holds until reset.

Back-pressure rules: a fault transfers on a clock edge where `flt_valid` and `flt_ready` are both high. The sender must hold `flt_valid`, `flt_kind` and `flt_streams` steady until that edge. `flt_ready` is high only while an event is in progress and the controller is not frozen.

Top module: `sev_freeze_ctrl`

## Requirements
- R1: While reset is asserted, `evt_init`, `frz_down`, `frz_up`, `flt_ready` and `strm_off` are all 0. The clock edge after reset is released enters the init state, so `evt_init` is high for the cycle after that edge.
- R2: When the hit and road end markers have both been sampled for the current event, `evt_init` is high for exactly one cycle, beginning at the edge that samples the later of the two. The markers may come in either order or on the same edge.
- R3: Markers from only one path, including repeated markers from that path, never produce `evt_init`.
- R4: A fault transfers only when `flt_valid` and `flt_ready` are both high. `flt_ready` is 0 during the init cycle and while frozen. A fault presented while frozen leaves `strm_off` unchanged.
- R5: An accepted fault with a kind below the threshold ORs `flt_streams` into `strm_off`, which is visible after the accepting edge. A fault at or above the threshold leaves `strm_off` unchanged.
- R6: `strm_off` bits only ever set, and only reset clears them.
- R7: After a fault at or above the threshold is accepted, no further `evt_init` is produced. `frz_down` rises on the edge that completes the markers of the event in flight. This includes the case where the completing marker and the fault are sampled on the same edge.
- R8: `frz_down` and `frz_up` are always equal. Once high, they stay high until reset.
- R9: Markers sampled on the init-cycle edge are dropped and do not count toward the next event.
- R10: The comparison is unsigned. A kind equal to the threshold counts as a freeze request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sev_thresh | input | KIND_W | Severity threshold |
| hit_eoe | input | 1 | Hit-path end-of-event marker |
| road_eoe | input | 1 | Road-path end-of-event marker |
| flt_valid | input | 1 | Fault report valid |
| flt_ready | output | 1 | Fault report accepted |
| flt_kind | input | KIND_W | Fault kind code |
| flt_streams | input | N_STREAMS | Streams named by the fault, one bit per stream |
| evt_init | output | 1 | Event-init pulse |
| frz_down | output | 1 | Freeze to downstream devices |
| frz_up | output | 1 | Freeze to upstream source |
| strm_off | output | N_STREAMS | Sticky stream-disable mask |

## Verification
The bench builds the block with four streams and a three-bit kind code. This makes every kind value reachable, so the threshold can be set at 5 and then at 7, the top of the range. The narrow mask lets each accumulated removal pattern be compared as a whole. The bench exercises both marker orders, simultaneous markers, and markers landing on the init edge. It also covers a fault that coincides with the event-completing marker.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_INIT      = 3'd1,
    ST_WAIT_EE   = 3'd2,
    ST_WAIT_DONE = 3'd3,
    ST_FROZEN    = 3'd4
  } ctrl_state_t;
endpackage

// File: rtl/sfc_eoe_track.sv
module sfc_eoe_track (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic clear,
  input  logic hit_mark,
  input  logic road_mark,
  output logic done
);
  logic hit_seen, road_seen;
  logic hit_now, road_now;

  assign hit_now  = hit_seen  | (arm & hit_mark);
  assign road_now = road_seen | (arm & road_mark);
  assign done     = arm & hit_now & road_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_seen  <= 1'b0;
      road_seen <= 1'b0;
    end else if (clear) begin
      hit_seen  <= 1'b0;
      road_seen <= 1'b0;
    end else begin
      hit_seen  <= hit_now;
      road_seen <= road_now;
    end
  end
endmodule

// File: rtl/sfc_sev_class.sv
module sfc_sev_class #(
  parameter int KIND_W = 4
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [KIND_W-1:0] thresh,
  output logic              fatal
);
  assign fatal = (kind >= thresh);
endmodule

// File: rtl/sfc_remove_mask.sv
module sfc_remove_mask #(
  parameter int N_STREAMS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 add_en,
  input  logic [N_STREAMS-1:0] add_bits,
  output logic [N_STREAMS-1:0] mask
);
  for (genvar i = 0; i < N_STREAMS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask[i] <= 1'b0;
      else        mask[i] <= mask[i] | (add_en & add_bits[i]);
    end
  end
endmodule

// File: rtl/sev_freeze_ctrl.sv
module sev_freeze_ctrl
  import sfc_pkg::*;
#(
  parameter int N_STREAMS = 8,
  parameter int KIND_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [KIND_W-1:0]    sev_thresh,
  input  logic                 hit_eoe,
  input  logic                 road_eoe,
  input  logic                 flt_valid,
  output logic                 flt_ready,
  input  logic [KIND_W-1:0]    flt_kind,
  input  logic [N_STREAMS-1:0] flt_streams,
  output logic                 evt_init,
  output logic                 frz_down,
  output logic                 frz_up,
  output logic [N_STREAMS-1:0] strm_off
);
  ctrl_state_t state, state_nx;
  logic fatal, flt_fire, ev_done, armed;

  assign armed     = (state == ST_WAIT_EE) || (state == ST_WAIT_DONE);
  assign flt_ready = armed;
  assign flt_fire  = flt_valid & flt_ready;

  sfc_eoe_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (armed),
    .clear     (state == ST_INIT),
    .hit_mark  (hit_eoe),
    .road_mark (road_eoe),
    .done      (ev_done)
  );

  sfc_sev_class #(.KIND_W(KIND_W)) u_class (
    .kind   (flt_kind),
    .thresh (sev_thresh),
    .fatal  (fatal)
  );

  sfc_remove_mask #(.N_STREAMS(N_STREAMS)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .add_en   (flt_fire & ~fatal),
    .add_bits (flt_streams),
    .mask     (strm_off)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:      state_nx = ST_INIT;
      ST_INIT:      state_nx = ST_WAIT_EE;
      ST_WAIT_EE: begin
        if (ev_done)             state_nx = (flt_fire && fatal) ? ST_FROZEN : ST_INIT;
        else if (flt_fire && fatal) state_nx = ST_WAIT_DONE;
      end
      ST_WAIT_DONE: if (ev_done) state_nx = ST_FROZEN;
      ST_FROZEN:    state_nx = ST_FROZEN;
      default:      state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign evt_init = (state == ST_INIT);
  assign frz_down = (state == ST_FROZEN);
  assign frz_up   = (state == ST_FROZEN);
endmodule

// File: rtl/sev_freeze_ctrl_chk.sv
module sev_freeze_ctrl_chk #(
  parameter int N_STREAMS = 8,
  parameter int KIND_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [KIND_W-1:0]    sev_thresh,
  input logic                 flt_valid,
  input logic                 flt_ready,
  input logic [KIND_W-1:0]    flt_kind,
  input logic [N_STREAMS-1:0] flt_streams,
  input logic                 evt_init,
  input logic                 frz_down,
  input logic                 frz_up,
  input logic [N_STREAMS-1:0] strm_off
);
  assert_init_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_init |=> !evt_init);
  assert_init_no_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_init |-> !flt_ready);
  assert_frozen_no_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frz_down |-> !flt_ready);
  assert_removal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_ready && (flt_kind < sev_thresh)) |=>
      ((strm_off & $past(flt_streams)) == $past(flt_streams)));
  assert_fatal_keeps_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_ready && (flt_kind >= sev_thresh)) |=> $stable(strm_off));
  assert_mask_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_off & $past(strm_off)) == $past(strm_off));
  assert_frozen_no_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frz_down |-> !evt_init);
  assert_freeze_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frz_down == frz_up);
  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frz_down |=> frz_down);
endmodule

bind sev_freeze_ctrl sev_freeze_ctrl_chk #(.N_STREAMS(N_STREAMS), .KIND_W(KIND_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sev_thresh  (sev_thresh),
  .flt_valid   (flt_valid),
  .flt_ready   (flt_ready),
  .flt_kind    (flt_kind),
  .flt_streams (flt_streams),
  .evt_init    (evt_init),
  .frz_down    (frz_down),
  .frz_up      (frz_up),
  .strm_off    (strm_off)
);

// File: tb/sev_freeze_ctrl_test.sv
module sev_freeze_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int KW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [KW-1:0] sev_thresh = 3'd5;
  logic          hit_eoe = 1'b0, road_eoe = 1'b0;
  logic          flt_valid = 1'b0;
  logic          flt_ready;
  logic [KW-1:0] flt_kind = '0;
  logic [NS-1:0] flt_streams = '0;
  logic          evt_init, frz_down, frz_up;
  logic [NS-1:0] strm_off;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  int exp_q[$];

  sev_freeze_ctrl #(.N_STREAMS(NS), .KIND_W(KW)) uut (
    .clk(clk), .rst_n(rst_n), .sev_thresh(sev_thresh),
    .hit_eoe(hit_eoe), .road_eoe(road_eoe),
    .flt_valid(flt_valid), .flt_ready(flt_ready), .flt_kind(flt_kind),
    .flt_streams(flt_streams), .evt_init(evt_init),
    .frz_down(frz_down), .frz_up(frz_up), .strm_off(strm_off)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Monitor: every init pulse must match the oldest expected cycle.
  always @(negedge clk) begin
    if (rst_n && evt_init && !finished) begin
      if (exp_q.size() == 0)
        check(0, "R3 unexpected event-init at cycle", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R2 event-init cycle", cyc, e);
      end
    end
  end

  // Driver tasks: called at a negedge, return at a negedge.
  task automatic marks(input bit h, input bit r, input bit expect_init);
    hit_eoe = h; road_eoe = r;
    if (expect_init) exp_q.push_back(cyc + 1);
    @(negedge clk);
    hit_eoe = 0; road_eoe = 0;
  endtask

  task automatic send_fault(input logic [KW-1:0] k, input logic [NS-1:0] s);
    while (!flt_ready) @(negedge clk);
    flt_valid = 1; flt_kind = k; flt_streams = s;
    @(negedge clk);
    flt_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle(2);
    check(evt_init == 0 && frz_down == 0 && frz_up == 0, "R1 outputs low in reset", evt_init, 0);
    check(flt_ready == 0, "R1 ready low in reset", flt_ready, 0);
    check(strm_off == 0, "R1 mask clear in reset", strm_off, 0);
    check(exp_q.size() == 0, "R2 pending init before reset", exp_q.size(), 0);
    exp_q.delete();
    rst_n = 1;
    exp_q.push_back(cyc + 1);
    idle(1);
    check(evt_init == 1, "R1 first init after reset", evt_init, 1);
    idle(1);
  endtask

  initial begin
    idle(1);
    do_reset();
    // R2 orders
    marks(1, 0, 0); idle(2); marks(0, 1, 1); idle(2);
    marks(0, 1, 0); marks(1, 0, 1); idle(2);
    marks(1, 1, 1); idle(2);
    // R3 repeated single path
    marks(1, 0, 0); marks(1, 0, 0); idle(1); marks(1, 0, 0); idle(4);
    check(evt_init == 0, "R3 no init on hit only", evt_init, 0);
    marks(0, 1, 1); idle(2);
    // R9 markers on the init edge dropped
    marks(1, 1, 1);            // now in init cycle
    marks(1, 0, 0);            // sampled on init edge: dropped
    marks(0, 1, 0); idle(3);
    check(evt_init == 0, "R9 init-edge hit dropped", evt_init, 0);
    marks(1, 0, 1); idle(2);
    // R5, R6, R10 removal below threshold 5
    send_fault(3'd2, 4'b0010);
    check(strm_off == 4'b0010, "R5 removal mask", strm_off, 4'b0010);
    send_fault(3'd4, 4'b0100);
    check(strm_off == 4'b0110, "R6 mask accumulates / R10 below threshold", strm_off, 4'b0110);
    check(frz_down == 0, "R5 no freeze on minor fault", frz_down, 0);
    // R7 deferred freeze, R10 equal counts as fatal
    send_fault(3'd5, 4'b0001);
    check(strm_off == 4'b0110, "R10 equal kind is fatal, mask kept", strm_off, 4'b0110);
    check(frz_down == 0, "R7 freeze deferred", frz_down, 0);
    send_fault(3'd1, 4'b1000);
    check(strm_off == 4'b1110, "R5 removal while freeze pending", strm_off, 4'b1110);
    marks(1, 0, 0); idle(2);
    check(frz_down == 0, "R7 freeze waits for road marker", frz_down, 0);
    marks(0, 1, 0);
    check(frz_down == 1, "R7 freeze after event done", frz_down, 1);
    check(frz_up == 1, "R8 upstream freeze", frz_up, 1);
    check(flt_ready == 0, "R4 ready low while frozen", flt_ready, 0);
    flt_valid = 1; flt_kind = 3'd0; flt_streams = 4'b0001;
    idle(3);
    flt_valid = 0;
    check(strm_off == 4'b1110, "R4 fault ignored while frozen", strm_off, 4'b1110);
    marks(1, 1, 0); idle(4);
    check(frz_down == 1 && frz_up == 1, "R8 freeze held", frz_down, 1);
    check(evt_init == 0, "R7 no init while frozen", evt_init, 0);
    // second run, threshold at the top of range
    sev_thresh = 3'd7;
    do_reset();
    check(strm_off == 0 && frz_down == 0, "R6 reset clears mask and freeze", strm_off, 0);
    send_fault(3'd6, 4'b0100);
    check(strm_off == 4'b0100, "R10 kind six below seven removes", strm_off, 4'b0100);
    marks(1, 0, 0);
    while (!flt_ready) @(negedge clk);
    road_eoe = 1; flt_valid = 1; flt_kind = 3'd7; flt_streams = 4'b0001;
    @(negedge clk);
    road_eoe = 0; flt_valid = 0;
    check(frz_down == 1, "R7 fault with completing marker freezes", frz_down, 1);
    check(evt_init == 0, "R7 no init on fatal completion", evt_init, 0);
    check(strm_off == 4'b0100, "R5 fatal leaves mask", strm_off, 4'b0100);
    idle(3);
    check(exp_q.size() == 0, "R2 all expected inits seen", exp_q.size(), 0);
    wrap_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    wrap_up();
  end
endmodule